// File: doc/BRIEF.md
# Byte-Lane Static RAM With Address Latch

This block is a clocked model of a static word memory. Each 18-bit word is split into two 9-bit lanes, and each lane has its own active-low select, so software or a bus bridge can read or write one half of a word without touching the other. Active-low chip enable, write enable and output enable pick the operation. The address enters through a transparent latch. While the latch-enable input is high, the latch follows the address pins. While it is low, the latch keeps the last captured address. Tying latch enable high gives a plain address path.

All reads and writes take effect on the rising clock edge, so the model can be synthesised. The bidirectional data pins are split into three signals: a data-in bus, a data-out bus and a 2-bit drive vector, one bit per lane. A top level combines these into a tristate pad ring. Read data and drive flags are registered and appear one cycle after the edge that sampled the command. The address width is a parameter. It defaults to 8 bits so that the default build stays small, and it is set to 16 for the full 64K-word array.

Top module: `lane_sram`

## Requirements
- R1: Synchronous reset clears both drive bits and sets the held latch address to zero. An access made with latch enable low right after reset therefore targets word 0.
- R2: While chip enable is high, no lane is written, whatever the write enable and lane selects are. The drive bits read 0 after every edge that samples chip enable high.
- R3: With chip enable low and write enable low, every selected lane stores its slice of data-in at the effective address on the clock edge. The drive vector is 0 after that edge.
- R4: With chip enable low and write enable high, every selected lane puts the stored word's slice on data-out one cycle after the edge.
- R5: Lane 0 covers bits 8:0 and is controlled by sel_n[0]. Lane 1 covers bits 17:9 and is controlled by sel_n[1]. Bit i of the drive vector belongs to lane i.
- R6: A write with only one lane selected leaves the 9 bits of the other lane unchanged.
- R7: When latch enable is high, the effective address equals the address input. When latch enable is low, the effective address is the address captured at the last edge that saw latch enable high.
- R8: Drive bit i is 1 after an edge exactly when that edge sampled output enable low, chip enable low, write enable high and sel_n[i] low. In every other case drive bit i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; high selects a read |
| oe_n | input | 1 | Output enable, active low |
| ale | input | 1 | Address latch enable; high = transparent |
| sel_n | input | 2 | Lane selects, active low; bit 0 low lane, bit 1 high lane |
| addr | input | ADDR_W | Word address |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |
| drive | output | 2 | Per-lane output-buffer enable for the pad tristate |

## Verification
The assertions assume that the control inputs are never X or Z on a sampling edge once reset is released. They also assume that reset is held for at least two edges, so the latch address is settled before the hold check starts. The bench changes inputs only on the falling clock edge, holds reset for four edges, and keeps latch enable low from reset until the first access. Read data is compared only on lanes that are both driven and previously written. Lanes that were never written hold undefined contents and are masked out of the comparison.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] sel_n;
    } ctrl_t;

    typedef struct packed {
        logic [LANES-1:0] wr;
        logic [LANES-1:0] rd;
        logic [LANES-1:0] drv;
    } lane_cmd_t;

    function automatic lane_cmd_t decode_ctrl(input ctrl_t c);
        lane_cmd_t r;
        for (int i = 0; i < LANES; i++) begin
            r.wr[i]  = !c.ce_n && !c.we_n && !c.sel_n[i];
            r.rd[i]  = !c.ce_n &&  c.we_n && !c.sel_n[i];
            r.drv[i] = r.rd[i] && !c.oe_n;
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_sram_addr_latch.sv
module lane_sram_addr_latch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] held_q;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (ale) begin
                held_q <= addr;
            end
        end
    end

    assign eff_addr = ale ? addr : held_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !ale && $past(!ale)) |-> (eff_addr == $past(eff_addr))); // R7

endmodule

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
(
    input  ctrl_t     ctrl,
    output lane_cmd_t cmd
);

    always_comb begin
        cmd = decode_ctrl(ctrl);
    end

endmodule

// File: rtl/lane_sram_lane.sv
module lane_sram_lane #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic              drv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[addr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive <= 1'b0;
            dout  <= '0;
        end else begin
            drive <= drv;
            if (rd) begin
                dout <= mem[addr];
            end
        end
    end

    AST_LANE_WRITE_DARK: assert property (@(posedge clk) disable iff (rst)
        wr |=> !drive); // R3

endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ale,
    input  logic [1:0]        sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       din,
    output logic [17:0]       dout,
    output logic [1:0]        drive
);

    logic [ADDR_W-1:0] eff_addr;
    ctrl_t             ctrl;
    lane_cmd_t         cmd;

    assign ctrl.ce_n  = ce_n;
    assign ctrl.we_n  = we_n;
    assign ctrl.oe_n  = oe_n;
    assign ctrl.sel_n = sel_n;

    lane_sram_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .ale      (ale),
        .addr     (addr),
        .eff_addr (eff_addr)
    );

    lane_sram_decode u_dec (
        .ctrl (ctrl),
        .cmd  (cmd)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_sram_lane #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .wr    (cmd.wr[i]),
            .rd    (cmd.rd[i]),
            .drv   (cmd.drv[i]),
            .addr  (eff_addr),
            .din   (din[i*LANE_W +: LANE_W]),
            .dout  (dout[i*LANE_W +: LANE_W]),
            .drive (drive[i])
        );

        AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
            (!oe_n && !ce_n && we_n && !sel_n[i]) |=> drive[i]); // R8

        AST_DESELECT_DARK: assert property (@(posedge clk) disable iff (rst)
            sel_n[i] |=> !drive[i]); // R5
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (drive == '0)); // R1

    AST_STANDBY_DARK: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (drive == '0)); // R2

    AST_WRITE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !we_n) |=> (drive == '0)); // R3

    AST_OE_DARK: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (drive == '0)); // R8

endmodule

// File: tb/lane_sram_test.sv
module lane_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam logic [17:0] LO_MASK = 18'h001FF;
    localparam logic [17:0] HI_MASK = 18'h3FE00;

    typedef struct packed {
        logic          wr;
        logic [1:0]    sel_n;
        logic [AW-1:0] a;
        logic [17:0]   d;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'b00, 8'h01, 18'h2A5A5},
        '{1'b1, 2'b00, 8'h02, 18'h1F00F},
        '{1'b0, 2'b00, 8'h01, 18'h00000},
        '{1'b0, 2'b00, 8'h02, 18'h00000},
        '{1'b1, 2'b10, 8'h01, 18'h00123},
        '{1'b0, 2'b00, 8'h01, 18'h00000},
        '{1'b1, 2'b01, 8'h02, 18'h3FE00},
        '{1'b0, 2'b00, 8'h02, 18'h00000},
        '{1'b0, 2'b01, 8'h01, 18'h00000},
        '{1'b0, 2'b10, 8'h02, 18'h00000},
        '{1'b1, 2'b00, 8'hFF, 18'h3FFFF},
        '{1'b0, 2'b00, 8'hFF, 18'h00000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          ale = 1'b0;
    logic [1:0]    sel_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic [1:0]    drive;

    int checks = 0;
    int errors = 0;

    logic [17:0] shadow [1 << AW];
    logic [17:0] known  [1 << AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sram #(.ADDR_W(AW)) uut (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .ale   (ale),
        .sel_n (sel_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout),
        .drive (drive)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic w, input logic o, input logic l,
                       input logic [1:0] s, input logic [AW-1:0] a, input logic [17:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; ale = l; sel_n = s; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [17:0] lane_mask(input logic [1:0] s);
        return ((!s[0]) ? LO_MASK : 18'h0) | ((!s[1]) ? HI_MASK : 18'h0);
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [1:0] s, input logic [17:0] d);
        logic [17:0] m;
        m = lane_mask(s);
        shadow[a] = (shadow[a] & ~m) | (d & m);
        known[a]  = known[a] | m;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL R4 watchdog act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            shadow[i] = '0;
            known[i]  = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 drive after reset", {16'h0, drive}, 18'h0);

        // R1: held address is zero, so this write with ale low lands at word 0
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h55, 18'h0ABCD);
        model_write(8'h00, 2'b00, 18'h0ABCD);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'h00, 18'h0);
        check("R1 reset latch address word0", dout, 18'h0ABCD);

        // table walk: R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k].wr) begin
                cyc(1'b0, 1'b0, 1'b0, 1'b1, VEC[k].sel_n, VEC[k].a, VEC[k].d);
                model_write(VEC[k].a, VEC[k].sel_n, VEC[k].d);
                check("R3 write leaves drive off", {16'h0, drive}, 18'h0);
            end else begin
                logic [17:0] m;
                cyc(1'b0, 1'b1, 1'b0, 1'b1, VEC[k].sel_n, VEC[k].a, 18'h0);
                m = lane_mask(VEC[k].sel_n) & known[VEC[k].a];
                check("R5 R8 read drive per lane", {16'h0, drive}, {16'h0, ~VEC[k].sel_n});
                check("R4 R6 read data", dout & m, shadow[VEC[k].a] & m);
            end
        end

        // R2: write attempt with chip disabled is ignored
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 8'h01, 18'h3FFFF);
        check("R2 standby drive", {16'h0, drive}, 18'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 8'h01, 18'h0);
        check("R2 standby read no drive", {16'h0, drive}, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'h01, 18'h0);
        check("R2 word unchanged after disabled write", dout, shadow[8'h01]);

        // R8: output enable high blocks drive on a read
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8'h02, 18'h0);
        check("R8 oe_n high no drive", {16'h0, drive}, 18'h0);

        // R6: low-lane-only write keeps high lane
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8'h10, 18'h2AAAA);
        model_write(8'h10, 2'b00, 18'h2AAAA);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 8'h10, 18'h15555);
        model_write(8'h10, 2'b10, 18'h15555);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'h10, 18'h0);
        check("R6 partial write merge", dout, (18'h2AAAA & HI_MASK) | (18'h15555 & LO_MASK));

        // R7: latch holds captured address while ale low
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8'h21, 18'h0C0C0);
        model_write(8'h21, 2'b00, 18'h0C0C0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 8'h20, 18'h11111);
        model_write(8'h20, 2'b00, 18'h11111);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h21, 18'h22222);
        model_write(8'h20, 2'b00, 18'h22222);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'h33, 18'h0);
        check("R7 held address read", dout, 18'h22222);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'h21, 18'h0);
        check("R7 neighbour untouched", dout, 18'h0C0C0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'h20, 18'h0);
        check("R7 transparent read", dout, shadow[8'h20]);

        // R5: only the high lane driven when low lane deselected
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 8'h20, 18'h0);
        check("R5 high lane drive bit", {16'h0, drive}, 18'h2);
        check("R5 high lane data", dout & HI_MASK, 18'h22222 & HI_MASK);

        cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule